// File: doc/BRIEF.md
# Configuration Image Header Ratio Detector

This block sits on the word stream of a configuration image while it is loaded. It counts the 32-bit words that a valid/data interface accepts. It samples one field in each of two fixed header words: one tells whether the image is encrypted, the other whether it is compressed. From those two flags and the configured bus width (16 or 32 bits) it derives the 2-bit clock-to-data ratio code that the loader must program before streaming the rest of the image. It neither decrypts, nor decompresses, nor stores any data.

A start strobe arms the block and clears its results. The ratio code is ready when the last header word (index 229, counting from 0) is accepted, and a one-cycle valid strobe marks that moment. The results then hold until the next start. An image that ends, marked by the last-word input, before the header is complete sets an error flag in place of the valid strobe.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset the block is armed at word index 0, with ratio_o = 0, and with encrypted_o, compressed_o, done_o and err_o all low.
- R2: encrypted_o is set from the cycle after the word with index 69 is accepted, to 1 when bits [3:2] of that word are nonzero and to 0 otherwise. The same bits in any other word have no effect.
- R3: compressed_o is set from the cycle after the word with index 229 is accepted, to 1 when bit 1 of that word is 0. Bit 1 of any other word has no effect.
- R4: done_o is high for exactly one cycle, the cycle after the word with index 229 is accepted. ratio_o is valid in that same cycle.
- R5: Ratio codes are 0 = x1, 1 = x2, 2 = x4, 3 = x8. An image that is neither encrypted nor compressed gets code 0 at either width.
- R6: Otherwise a compressed image gets code 2 and an encrypted-only image gets code 1. When wide_i (1 = 32-bit, 0 = 16-bit) is high in the cycle word 229 is accepted, the code is one higher: compressed gives 3, encrypted-only gives 2.
- R7: A word accepted with last_i high and an index below 229 sets err_o from the next cycle and stops detection. done_o does not pulse. A flag already captured is kept.
- R8: A cycle with valid_i low does not advance the word index.
- R9: After done_o or err_o, further words change no output until start_i.
- R10: start_i clears every output and rearms at index 0 from the next cycle. A word presented in the same cycle as start_i is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clear results and rearm at word 0 |
| valid_i | input | 1 | data_i carries a word this cycle |
| data_i | input | 32 | Image word |
| last_i | input | 1 | Final word of the image, qualified by valid_i |
| wide_i | input | 1 | Configuration width: 1 = 32-bit, 0 = 16-bit |
| ratio_o | output | 2 | Clock-to-data ratio code |
| encrypted_o | output | 1 | Image is encrypted |
| compressed_o | output | 1 | Image is compressed |
| done_o | output | 1 | One-cycle result-valid strobe |
| err_o | output | 1 | Image ended before the header was complete |

## Verification
Full 230-word headers are sent with all four flag combinations at both widths. This separates the x1 case, which ignores width, from the encrypted-only and compressed paths and their doubling. Every word other than 69 and 229 has the tested bits set the wrong way, so a one-off in the index is exposed. Streams with idle gaps separate counting of accepted words from counting of cycles. Streams that end at words 30 and 100 show the error path with and without an encryption flag already captured. Words sent after completion, and a word presented together with start, confirm that state is held and that rearming starts at index 0.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;
  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;
endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
  parameter int unsigned LAST_IDX = 229,
  parameter int unsigned CNT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_last_o
);
  localparam logic [CNT_W-1:0] LastVal = CNT_W'(LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (clr_i)                    cnt_o <= '0;
    else if (adv_i && cnt_o != LastVal) cnt_o <= cnt_o + 1'b1;
  end

  assign at_last_o = (cnt_o == LastVal);

  a_r8_idle_holds_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/hdr_field_flag.sv
module hdr_field_flag #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned IDX         = 69,
  parameter int unsigned FW          = 2,
  parameter bit          SET_ON_ZERO = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [FW-1:0]    field_i,
  output logic             flag_o,
  output logic             next_o
);
  logic hit, cur;

  assign hit = adv_i && (cnt_i == CNT_W'(IDX));

  generate
    if (SET_ON_ZERO) begin : g_zero
      assign cur = (field_i == '0);
    end else begin : g_nonzero
      assign cur = (field_i != '0);
    end
  endgenerate

  assign next_o = hit ? cur : flag_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (clr_i)  flag_o <= 1'b0;
    else if (hit)    flag_o <= cur;
  end

  // R2/R3: flag moves only on its own word index
  a_r2_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/hdr_ratio_enc.sv
module hdr_ratio_enc
  import hdr_ratio_pkg::*;
(
  input  logic   enc_i,
  input  logic   cmp_i,
  input  logic   wide_i,
  output ratio_e ratio_o
);
  logic [1:0] base;

  always_comb begin
    base = cmp_i ? 2'd2 : 2'd1;
    if (!enc_i && !cmp_i) ratio_o = RATIO_X1;
    else                  ratio_o = ratio_e'(base + {1'b0, wide_i});
  end
endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
  import hdr_ratio_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENC_IDX = 69,
  parameter int unsigned CMP_IDX = 229,
  parameter int unsigned ENC_MSB = 3,
  parameter int unsigned ENC_LSB = 2,
  parameter int unsigned CMP_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              wide_i,
  output logic [1:0]        ratio_o,
  output logic              encrypted_o,
  output logic              compressed_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned CNT_W = $clog2(CMP_IDX + 1);
  localparam int unsigned ENC_W = ENC_MSB - ENC_LSB + 1;
  localparam logic [DATA_W-1:0] USED_MASK =
    (((DATA_W)'(1) << ENC_W) - 1'b1) << ENC_LSB | ((DATA_W)'(1) << CMP_BIT);

  logic             active_q, adv, fin, early;
  logic [CNT_W-1:0] cnt;
  logic             at_last, enc_next, cmp_next;
  ratio_e           ratio_d, ratio_q;
  logic             data_unused;

  assign data_unused = ^(data_i & ~USED_MASK);

  assign adv   = active_q && valid_i && !start_i;
  assign fin   = adv && at_last;
  assign early = adv && last_i && !at_last;

  hdr_word_counter #(.LAST_IDX(CMP_IDX), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(start_i), .adv_i(adv),
    .cnt_o(cnt), .at_last_o(at_last)
  );

  hdr_field_flag #(.CNT_W(CNT_W), .IDX(ENC_IDX), .FW(ENC_W), .SET_ON_ZERO(1'b0)) u_enc (
    .clk_i, .rst_ni, .clr_i(start_i), .adv_i(adv), .cnt_i(cnt),
    .field_i(data_i[ENC_MSB:ENC_LSB]), .flag_o(encrypted_o), .next_o(enc_next)
  );

  hdr_field_flag #(.CNT_W(CNT_W), .IDX(CMP_IDX), .FW(1), .SET_ON_ZERO(1'b1)) u_cmp (
    .clk_i, .rst_ni, .clr_i(start_i), .adv_i(adv), .cnt_i(cnt),
    .field_i(data_i[CMP_BIT]), .flag_o(compressed_o), .next_o(cmp_next)
  );

  hdr_ratio_enc u_ratio (.enc_i(enc_next), .cmp_i(cmp_next), .wide_i, .ratio_o(ratio_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      ratio_q  <= RATIO_X1;
    end else if (start_i) begin
      active_q <= 1'b1;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      ratio_q  <= RATIO_X1;
    end else begin
      done_o <= fin;
      if (fin) begin
        active_q <= 1'b0;
        ratio_q  <= ratio_d;
      end
      if (early) begin
        active_q <= 1'b0;
        err_o    <= 1'b1;
      end
    end
  end

  assign ratio_o = ratio_q;

  a_r4_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_err_excludes_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o);
  a_r5_plain_is_x1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !encrypted_o && !compressed_o) |-> ratio_o == 2'd0);
  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !start_i) |=> ($stable(ratio_o) && $stable(err_o) &&
                                 $stable(encrypted_o) && $stable(compressed_o)));
  a_r10_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ratio_o == 2'd0 && !err_o && !done_o && !encrypted_o && !compressed_o));
endmodule

// File: tb/sim_hdr_ratio_detect.sv
`timescale 1ns/1ps
module sim_hdr_ratio_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, valid = 1'b0, last = 1'b0, wide = 1'b0;
  logic [31:0] data = '0;
  logic [1:0]  ratio;
  logic        enc, cmp, done, err;

  int vectors = 0;
  int miscompares = 0;

  // behavioural reference state
  int   m_cnt = 0;
  bit   m_active = 1'b1;
  bit   m_enc = 1'b0, m_cmp = 1'b0, m_done = 1'b0, m_err = 1'b0;
  int   m_ratio = 0;

  always #2.5 clk = ~clk;

  hdr_ratio_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid), .data_i(data),
    .last_i(last), .wide_i(wide), .ratio_o(ratio), .encrypted_o(enc),
    .compressed_o(cmp), .done_o(done), .err_o(err)
  );

  task automatic chk(string tag, string what, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    vectors++;
    chk(tag, "ratio", int'(ratio), m_ratio);
    chk(tag, "encrypted", int'(enc), int'(m_enc));
    chk(tag, "compressed", int'(cmp), int'(m_cmp));
    chk(tag, "done", int'(done), int'(m_done));
    chk(tag, "err", int'(err), int'(m_err));
  endtask

  task automatic cycle(bit s, bit v, logic [31:0] d, bit l, bit w, string tag);
    bit c;
    start = s; valid = v; data = d; last = l; wide = w;
    if (s) begin
      m_cnt = 0; m_active = 1; m_enc = 0; m_cmp = 0; m_err = 0; m_ratio = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_active && v) begin
        if (m_cnt == 69) m_enc = (d[3:2] != 2'b00);
        if (m_cnt == 229) begin
          c = ~d[1];
          m_cmp = c;
          if (!m_enc && !c) m_ratio = 0;
          else m_ratio = (c ? 2 : 1) + int'(w);
          m_done = 1;
          m_active = 0;
        end else if (l) begin
          m_err = 1;
          m_active = 0;
        end
        m_cnt++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [31:0] word_val(int i, logic [1:0] encf, logic cmpbit);
    logic [31:0] v;
    v = 32'h3c1d_7a55 ^ (i * 32'h0105_9e37);
    if (i == 69)       v[3:2] = encf;
    else if (i == 229) v[1]   = cmpbit;
    else               v[3:1] = 3'b110; // decoys: wrong-way bits elsewhere
    return v;
  endfunction

  task automatic run_img(int n, logic [1:0] encf, logic cmpbit, bit w, bit use_last,
                         int gap, string tag);
    for (int i = 0; i < n; i++) begin
      if (gap != 0 && i % gap == 0) cycle(0, 0, 32'hffff_ffff, 1, w, "R8");
      cycle(0, 1, word_val(i, encf, cmpbit), use_last && (i == n - 1), w, tag);
    end
    cycle(0, 0, '0, 0, w, "R4");
    cycle(0, 0, '0, 0, w, "R4");
  endtask

  task automatic rearm();
    cycle(1, 0, '0, 0, 0, "R10");
  endtask

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    cycle(0, 0, '0, 0, 0, "R1");

    rearm(); run_img(230, 2'b00, 1'b1, 0, 0, 0, "R5");  // plain, 16 -> x1
    rearm(); run_img(230, 2'b00, 1'b1, 1, 0, 0, "R5");  // plain, 32 -> x1
    rearm(); run_img(230, 2'b01, 1'b1, 0, 0, 0, "R2");  // encrypted, 16 -> x2
    rearm(); run_img(230, 2'b10, 1'b1, 1, 0, 0, "R6");  // encrypted, 32 -> x4
    rearm(); run_img(230, 2'b00, 1'b0, 0, 0, 0, "R3");  // compressed, 16 -> x4
    rearm(); run_img(230, 2'b11, 1'b0, 1, 0, 0, "R6");  // both, 32 -> x8
    rearm(); run_img(230, 2'b01, 1'b0, 0, 0, 3, "R8");  // gaps, both, 16 -> x4
    rearm(); run_img(230, 2'b00, 1'b0, 1, 1, 0, "R4");  // last on word 229 is not an error
    run_img(40, 2'b11, 1'b1, 0, 0, 0, "R9");            // ignored after done
    rearm(); run_img(100, 2'b01, 1'b0, 0, 1, 0, "R7");  // early end, enc kept
    rearm(); run_img(30, 2'b11, 1'b0, 1, 1, 0, "R7");   // early end before word 69
    run_img(230, 2'b11, 1'b0, 1, 0, 0, "R9");           // ignored after error
    cycle(1, 1, word_val(0, 2'b00, 1'b1), 0, 0, "R10"); // word with start not counted
    run_img(230, 2'b00, 1'b0, 1, 0, 0, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule